// File: doc/BRIEF.md
# Mode Stack Return Unit

This block updates the processor status word and the stack pointers when software returns from an exception handler or from a non-maskable interrupt handler. The status word holds the current mode bits together with a history of earlier modes. Each earlier level occupies a 10-bit slot above the current one. A return removes the current level by shifting the history down one slot. The two most significant bits are left as they were.

After the shift, the block checks the user-mode flag that has moved into the current level. If that flag is set, the active stack pointer is saved as the kernel stack pointer and the user stack pointer becomes the active one. The block also sets the pending flag if the restore flag was clear before the shift. A return from NMI also always sets the NMI-mask flag.

The surrounding pipeline presents the current status word and the three stack-pointer values together with a one-cycle return strobe and a return-kind bit. The updated values are registered on that clock edge. A done pulse marks them during the following cycle. The outputs hold their value until the next strobe.

Top module: `msr_return_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `status_out`, `sp_out` and `ksp_out` become zero and `done` becomes low.
- R2: On a return, bits [31:30] of `status_out` equal bits [31:30] of `status_in`.
- R3: On a return, bits [17:0] of `status_out` take bits [27:10] of `status_in`, and bits [29:18] of `status_out` are zero. Bits 7 and 9 are the exceptions, changed only as R6 and R7 describe.
- R4: On a return where the user flag after the shift is set, `ksp_out` takes `sp_in` and `sp_out` takes `usp_in`. The user flag is bit 8 of the result, which comes from bit 18 of `status_in`.
- R5: On a return where the user flag after the shift is clear, `sp_out` takes `sp_in` and `ksp_out` takes `ksp_in`.
- R6: On a return, bit 7 of `status_out` (pending) is forced to 1 when bit 8 of `status_in` (restore, sampled before the shift) is 0. Otherwise bit 7 keeps the shifted value, bit 17 of `status_in`.
- R7: A return with `ret_nmi` = 1 forces bit 9 of `status_out` (NMI mask) to 1. With `ret_nmi` = 0, bit 9 keeps the shifted value, bit 19 of `status_in`.
- R8: The outputs change on the clock edge that samples `ret_valid` = 1. `done` is high for exactly the cycle after each such edge and low otherwise.
- R9: When `ret_valid` is 0, `status_out`, `sp_out` and `ksp_out` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | One-cycle return strobe |
| ret_nmi | input | 1 | Return kind: 1 = return from NMI, 0 = return from exception |
| status_in | input | 32 | Current status word |
| sp_in | input | 32 | Current active stack pointer |
| ksp_in | input | 32 | Current saved kernel stack pointer |
| usp_in | input | 32 | Current user stack pointer |
| status_out | output | 32 | Status word after the return |
| sp_out | output | 32 | Active stack pointer after the return |
| ksp_out | output | 32 | Kernel stack pointer after the return |
| done | output | 1 | High for the cycle after a return was taken |

## Verification
Some properties hold on every cycle, and the bound checker tests those: the preserved top bits and the cleared middle bits, the forced NMI mask, the user stack swap, the done timing, and the hold of the outputs when no strobe arrives. Other behaviour needs chosen data to show up. The conditional pending flag depends on the pre-shift restore bit, so it needs patterns both with and without that bit. The choice of stack when the user flag is clear is also shown only by the bench's scenarios. Back-to-back strobes show that each done pulse matches the right result.

// File: rtl/msr_pkg.sv
// Shared sizes and the result record for the mode stack return unit.
// Assumes a status word with a kept top field, a cleared gap and a history
// region made of equal-width mode levels.
package msr_pkg;
    parameter int DATA_W  = 32;  // status word width
    parameter int SP_W    = 32;  // stack pointer width
    parameter int KEEP_W  = 2;   // top bits preserved across a return
    parameter int GAP_W   = 2;   // bits between kept field and history, cleared
    parameter int LEVEL_W = 10;  // width of one mode-history level
    parameter int U_POS   = 8;   // user flag, position after the shift
    parameter int P_POS   = 7;   // pending flag, position after the shift
    parameter int R_POS   = 8;   // restore flag, position before the shift
    parameter int M_POS   = 9;   // NMI mask flag, position after the shift

    typedef enum logic {
        RET_EXC = 1'b0,
        RET_NMI = 1'b1
    } ret_kind_e;
endpackage

// File: rtl/msr_hist_shift.sv
// Pops one mode level from the status word.
// Keeps the top KEEP_W bits, clears the gap, shifts the history down by
// LEVEL_W and applies the pending and NMI-mask rules. Purely combinational.
// Assumes KEEP_W + GAP_W + LEVEL_W < DATA_W.
module msr_hist_shift
    import msr_pkg::*;
#(
    parameter int D_W  = DATA_W,
    parameter int K_W  = KEEP_W,
    parameter int G_W  = GAP_W,
    parameter int L_W  = LEVEL_W,
    parameter int U_B  = U_POS,
    parameter int P_B  = P_POS,
    parameter int R_B  = R_POS,
    parameter int M_B  = M_POS
) (
    input  logic [D_W-1:0] status_in,
    input  ret_kind_e      kind,
    output logic [D_W-1:0] status_next,
    output logic           to_user
);
    localparam int HIST_W = D_W - K_W - G_W;
    localparam int LOW_W  = HIST_W - L_W;

    logic [D_W-1:0] shifted;
    logic           restore_pre;

    // Restore flag is taken from the word before the shift.
    assign restore_pre = status_in[R_B];

    // Relocate each history bit one level down; keep the top field.
    always_comb begin
        shifted = '0;
        shifted[D_W-1 -: K_W] = status_in[D_W-1 -: K_W];
        for (int i = 0; i < LOW_W; i++) begin
            shifted[i] = status_in[i + L_W];
        end
    end

    // Apply the pending and NMI-mask rules to the shifted word.
    always_comb begin
        status_next = shifted;
        if (!restore_pre) begin
            status_next[P_B] = 1'b1;
        end
        if (kind == RET_NMI) begin
            status_next[M_B] = 1'b1;
        end
    end

    // The user flag after the shift selects the stack swap.
    assign to_user = shifted[U_B];
endmodule

// File: rtl/msr_sp_select.sv
// Chooses the next active and kernel stack pointers.
// When returning to user mode, the active pointer is saved as the kernel
// pointer and the user pointer becomes active. Purely combinational.
module msr_sp_select #(
    parameter int W = 32
) (
    input  logic         to_user,
    input  logic [W-1:0] sp_in,
    input  logic [W-1:0] ksp_in,
    input  logic [W-1:0] usp_in,
    output logic [W-1:0] sp_next,
    output logic [W-1:0] ksp_next
);
    // Swap on a return to user mode, pass through otherwise.
    always_comb begin
        if (to_user) begin
            sp_next  = usp_in;
            ksp_next = sp_in;
        end else begin
            sp_next  = sp_in;
            ksp_next = ksp_in;
        end
    end
endmodule

// File: rtl/msr_return_unit.sv
// Top of the mode stack return unit.
// On a one-cycle return strobe it registers the popped status word and the
// chosen stack pointers, then pulses done for one cycle. Without a strobe
// all outputs hold. Assumes the inputs are stable at the strobe edge.
module msr_return_unit
    import msr_pkg::*;
#(
    parameter int DATA_W  = msr_pkg::DATA_W,
    parameter int SP_W    = msr_pkg::SP_W,
    parameter int KEEP_W  = msr_pkg::KEEP_W,
    parameter int GAP_W   = msr_pkg::GAP_W,
    parameter int LEVEL_W = msr_pkg::LEVEL_W,
    parameter int U_POS   = msr_pkg::U_POS,
    parameter int P_POS   = msr_pkg::P_POS,
    parameter int R_POS   = msr_pkg::R_POS,
    parameter int M_POS   = msr_pkg::M_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_nmi,
    input  logic [DATA_W-1:0] status_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [SP_W-1:0]   ksp_in,
    input  logic [SP_W-1:0]   usp_in,
    output logic [DATA_W-1:0] status_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [SP_W-1:0]   ksp_out,
    output logic              done
);
    logic [DATA_W-1:0] status_next;
    logic [SP_W-1:0]   sp_next;
    logic [SP_W-1:0]   ksp_next;
    logic              to_user;
    ret_kind_e         kind;

    assign kind = ret_nmi ? RET_NMI : RET_EXC;

    msr_hist_shift #(
        .D_W (DATA_W),
        .K_W (KEEP_W),
        .G_W (GAP_W),
        .L_W (LEVEL_W),
        .U_B (U_POS),
        .P_B (P_POS),
        .R_B (R_POS),
        .M_B (M_POS)
    ) u_shift (
        .status_in   (status_in),
        .kind        (kind),
        .status_next (status_next),
        .to_user     (to_user)
    );

    msr_sp_select #(
        .W (SP_W)
    ) u_spsel (
        .to_user  (to_user),
        .sp_in    (sp_in),
        .ksp_in   (ksp_in),
        .usp_in   (usp_in),
        .sp_next  (sp_next),
        .ksp_next (ksp_next)
    );

    // Capture the updated state on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_out <= '0;
            sp_out     <= '0;
            ksp_out    <= '0;
        end else if (ret_valid) begin
            status_out <= status_next;
            sp_out     <= sp_next;
            ksp_out    <= ksp_next;
        end
    end

    // Pulse done for the cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= ret_valid;
        end
    end
endmodule

// File: rtl/msr_return_unit_chk.sv
// Port-level properties of the mode stack return unit, bound to the top.
module msr_return_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int SP_W    = 32,
    parameter int KEEP_W  = 2,
    parameter int GAP_W   = 2,
    parameter int LEVEL_W = 10,
    parameter int U_POS   = 8,
    parameter int M_POS   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_valid,
    input logic              ret_nmi,
    input logic [DATA_W-1:0] status_in,
    input logic [SP_W-1:0]   sp_in,
    input logic [SP_W-1:0]   ksp_in,
    input logic [SP_W-1:0]   usp_in,
    input logic [DATA_W-1:0] status_out,
    input logic [SP_W-1:0]   sp_out,
    input logic [SP_W-1:0]   ksp_out,
    input logic              done
);
    localparam int HIST_W = DATA_W - KEEP_W - GAP_W;
    localparam int LOW_W  = HIST_W - LEVEL_W;
    localparam int U_PRE  = U_POS + LEVEL_W;

    AST_KEEP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> status_out[DATA_W-1 -: KEEP_W] == $past(status_in[DATA_W-1 -: KEEP_W])); // R2
    AST_MID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> status_out[DATA_W-KEEP_W-1:LOW_W] == '0); // R3
    AST_USER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && status_in[U_PRE]) |=> (sp_out == $past(usp_in)) && (ksp_out == $past(sp_in))); // R4
    AST_NMI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_nmi) |=> status_out[M_POS]); // R7
    AST_DONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> done); // R8
    AST_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> !done); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> $stable(status_out) && $stable(sp_out) && $stable(ksp_out)); // R9
endmodule

bind msr_return_unit msr_return_unit_chk #(
    .DATA_W  (DATA_W),
    .SP_W    (SP_W),
    .KEEP_W  (KEEP_W),
    .GAP_W   (GAP_W),
    .LEVEL_W (LEVEL_W),
    .U_POS   (U_POS),
    .M_POS   (M_POS)
) u_chk (.*);

// File: tb/msr_return_unit_tb.sv
// Scoreboard bench for the mode stack return unit.
module msr_return_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic        ret_nmi = 1'b0;
    logic [31:0] status_in = '0;
    logic [31:0] sp_in = '0;
    logic [31:0] ksp_in = '0;
    logic [31:0] usp_in = '0;
    logic [31:0] status_out;
    logic [31:0] sp_out;
    logic [31:0] ksp_out;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0] st;
        logic [31:0] sp;
        logic [31:0] ksp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t last;

    always #2 clk = ~clk;

    msr_return_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_nmi(ret_nmi),
        .status_in(status_in), .sp_in(sp_in), .ksp_in(ksp_in), .usp_in(usp_in),
        .status_out(status_out), .sp_out(sp_out), .ksp_out(ksp_out), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one strobe, expected result pushed to the scoreboard.
    task automatic do_ret(input logic nmi, input logic [31:0] st, input logic [31:0] sp,
                          input logic [31:0] ksp, input logic [31:0] usp, input string tag);
        exp_t e;
        e.st = (st & 32'hC000_0000) | ((st & 32'h0FFF_FFFF) >> 10);
        if (!st[8]) e.st[7] = 1'b1;
        if (nmi)    e.st[9] = 1'b1;
        if (e.st[8]) begin
            e.sp = usp; e.ksp = sp;
        end else begin
            e.sp = sp;  e.ksp = ksp;
        end
        e.tag = tag;
        @(negedge clk);
        ret_valid = 1'b1; ret_nmi = nmi; status_in = st;
        sp_in = sp; ksp_in = ksp; usp_in = usp;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ret_valid = 1'b0;
            status_in = 32'hDEAD_BEEF ^ i; sp_in = 32'h1111 * i;
            ksp_in = 32'h2222; usp_in = 32'h3333; ret_nmi = i[0];
        end
    endtask

    // Monitor: pop and compare on each done pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    chk("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    last = sb.pop_front();
                    chk({last.tag, " status"}, status_out, last.st);
                    chk({last.tag, " sp"},     sp_out,     last.sp);
                    chk({last.tag, " ksp"},    ksp_out,    last.ksp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status reset", status_out, 32'h0);
        chk("R1 sp reset", sp_out, 32'h0);
        chk("R1 ksp reset", ksp_out, 32'h0);
        chk("R1 done reset", {31'b0, done}, 32'h0);
        rst_n = 1'b1;

        // All ones: top kept, R set so P not forced, user swap (R2 R4).
        do_ret(1'b0, 32'hFFFF_FFFF, 32'hA000_0001, 32'hB000_0002, 32'hC000_0003, "R2 R4 allones");
        idle(1);
        // Zero word: P forced, no swap (R5 R6).
        do_ret(1'b0, 32'h0000_0000, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000, "R5 R6 zero");
        idle(1);
        // NMI sets mask (R7).
        do_ret(1'b1, 32'h0000_0000, 32'h10, 32'h20, 32'h30, "R7 nmi");
        idle(1);
        // Gap bits cleared, history moved (R3).
        do_ret(1'b0, 32'h3000_0C00 | 32'h0000_0100, 32'h1, 32'h2, 32'h3, "R3 gap");
        idle(1);
        // User flag from bit 18 and restore at bit 8 (R4 R6).
        do_ret(1'b0, 32'h0004_0100, 32'h55, 32'h66, 32'h77, "R4 R6 user");
        // Back to back, second is NMI with bit 19 clear and bit 17 set (R8 R7).
        do_ret(1'b1, 32'h4002_0100, 32'h88, 32'h99, 32'hAA, "R8 R7 b2b");
        do_ret(1'b0, 32'h8008_0000, 32'hBB, 32'hCC, 32'hDD, "R8 R7 b2b2");
        idle(1);
        // Hold with changing inputs (R9): expect last result held and done low.
        idle(4);
        chk("R9 hold status", status_out, last.st);
        chk("R9 hold sp", sp_out, last.sp);
        chk("R9 hold ksp", ksp_out, last.ksp);
        chk("R8 done idle", {31'b0, done}, 32'h0);
        chk("R8 scoreboard drained", sb.size(), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule